// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block is the digital sequencer that steps an analog-to-digital converter through a run of conversions. Software sets up the run length, the trigger behaviour and interrupt gating through a small register bus. A run begins on a software start write or on an external trigger input. The trigger can respond to either edge or to either level. While a run is active the block holds a conversion request high. It counts the done strobes that the converter returns. After the last one it ends the run and raises a sequence-complete flag.

Any write to the control register stops a run in progress and does not begin a new one. Done strobes that arrive while no run is active are discarded. The interrupt output, and the interrupt bit in the status register, follow the complete flag only while the interrupt enable is set.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x04, which gives a run length of 4 with the trigger and the interrupt disabled. The status register (address 1) reads 0x00 and conv_req is low.
- R2: Control bits [3:0] hold the run length in plain binary (bit 3 has weight 8, bit 0 has weight 1). For a value from 1 to 8, a run ends after exactly that many done strobes.
- R3: A length value of 0, and any value above 8, gives a run of 8 conversions.
- R4: Writing address 1 with bit 0 set while idle starts a run: conv_req is high from the next cycle and status bit 0 (complete) is cleared. A start request during an active run is ignored.
- R5: The done strobe that completes the run clears conv_req and sets status bit 0. Both changes are visible in the cycle that follows that strobe.
- R6: Any write to address 0 ends an active run, with conv_req low in the next cycle, and does not start a new run. Done strobes that arrive afterwards, before the next start, have no effect. Status bit 2 reads back the active state.
- R7: Status bit 1 and the irq output equal the complete flag when control bit 7 (interrupt enable) is 1, and are 0 when it is 0.
- R8: Writes to status bit 1 have no effect.
- R9: Control bit 4 enables the external trigger. Control bits [6:5] select the trigger mode: 00 falling edge, 01 rising edge, 10 high level, 11 low level. The trigger input passes through two synchronizing flops before it is evaluated.
- R10: In a level mode, a new run starts again after completion for as long as the level stays active.
- R11: If a control write and the final done strobe fall in the same cycle, the abort wins: the run is not counted as complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status/command |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ext_trig | input | 1 | Asynchronous external trigger |
| conv_done | input | 1 | One-cycle strobe from the converter for each finished conversion |
| conv_req | output | 1 | High while a run is active |
| irq | output | 1 | Gated sequence-complete interrupt |

## Verification
Two things can happen in the same clock edge: the abort caused by a control-register write and the done strobe that would finish the run. The bench starts a two-conversion run and delivers one strobe. It then drives the second strobe and a control write in the same cycle. The run must end with conv_req low and with status bit 0 and irq both still 0, which shows that the abort took precedence over completion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int DATA_W = 8;
   localparam int LEN_W  = 4;

   typedef enum logic [1:0] {
      TRG_FALL = 2'b00,
      TRG_RISE = 2'b01,
      TRG_HIGH = 2'b10,
      TRG_LOW  = 2'b11
   } trig_mode_e;

   typedef struct packed {
      logic             irq_en;
      trig_mode_e       mode;
      logic             trig_en;
      logic [LEN_W-1:0] len;
   } ctrl_t;

   localparam logic [DATA_W-1:0] CTRL_RESET = 8'h04;
   localparam logic              ADDR_CTRL  = 1'b0;
   localparam logic              ADDR_STAT  = 1'b1;
endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect
   import adc_seq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_raw,
   input  logic       enable,
   input  trig_mode_e mode,
   output logic       trig_evt
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("adc_trig_detect: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= trig_raw;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[i] <= 1'b0;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= synced;
   end

   always_comb begin
      unique case (mode)
         TRG_FALL: trig_evt = prev_q & ~synced;
         TRG_RISE: trig_evt = synced & ~prev_q;
         TRG_HIGH: trig_evt = synced;
         TRG_LOW:  trig_evt = ~synced;
         default:  trig_evt = 1'b0;
      endcase
      trig_evt = trig_evt & enable;
   end
endmodule

// File: rtl/adc_seq_counter.sv
module adc_seq_counter
   import adc_seq_pkg::*;
#(
   parameter int MAX_LEN = 8,
   localparam int CNT_W  = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] len_field,
   input  logic             start,
   input  logic             abort,
   input  logic             done,
   output logic             active,
   output logic             complete,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] len_eff
);
   if (MAX_LEN < 1 || MAX_LEN > (1 << LEN_W) - 1) begin : g_bad_len
      $error("adc_seq_counter: MAX_LEN out of range for the length field");
   end

   localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_LEN);

   always_comb begin
      if (len_field == '0 || 32'(len_field) > MAX_LEN) len_eff = MAX_C;
      else                                            len_eff = CNT_W'(len_field);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         complete <= 1'b0;
         cnt      <= '0;
      end else if (abort) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start && !active) begin
         active   <= 1'b1;
         complete <= 1'b0;
         cnt      <= '0;
      end else if (active && done) begin
         if (cnt == len_eff - CNT_W'(1)) begin
            active   <= 1'b0;
            complete <= 1'b1;
            cnt      <= '0;
         end else begin
            cnt <= cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              complete,
   input  logic              active,
   output ctrl_t             ctrl,
   output logic              ctrl_wr,
   output logic              sw_start,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   ctrl_t ctrl_q;
   logic  irq_flag;

   assign ctrl_wr  = bus_wr && (bus_addr == ADDR_CTRL);
   assign sw_start = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= ctrl_t'(CTRL_RESET);
      else if (ctrl_wr) ctrl_q <= ctrl_t'(bus_wdata);
   end

   assign ctrl     = ctrl_q;
   assign irq_flag = ctrl_q.irq_en & complete;
   assign irq      = irq_flag;

   always_comb begin
      if (bus_addr == ADDR_CTRL) bus_rdata = DATA_W'(ctrl_q);
      else                       bus_rdata = {5'b0, active, irq_flag, complete};
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int MAX_LEN     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_trig,
   input  logic              conv_done,
   output logic              conv_req,
   output logic              irq
);
   localparam int CNT_W = $clog2(MAX_LEN + 1);

   ctrl_t            ctrl;
   logic             ctrl_wr;
   logic             sw_start;
   logic             trig_evt;
   logic             seq_start;
   logic             active;
   logic             complete;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] len_eff;

   adc_seq_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .complete  (complete),
      .active    (active),
      .ctrl      (ctrl),
      .ctrl_wr   (ctrl_wr),
      .sw_start  (sw_start),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   adc_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_raw (ext_trig),
      .enable   (ctrl.trig_en),
      .mode     (ctrl.mode),
      .trig_evt (trig_evt)
   );

   assign seq_start = sw_start | trig_evt;

   adc_seq_counter #(.MAX_LEN(MAX_LEN)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .len_field (ctrl.len),
      .start     (seq_start),
      .abort     (ctrl_wr),
      .done      (conv_done),
      .active    (active),
      .complete  (complete),
      .cnt       (cnt),
      .len_eff   (len_eff)
   );

   assign conv_req = active;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_wr,
   input logic             seq_start,
   input logic             conv_done,
   input logic             conv_req,
   input logic             complete,
   input logic             irq,
   input logic             irq_en,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] len_eff
);
   AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !conv_req) else $error("abort left run active"); // R6
   AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(complete) |-> ($past(conv_done) && $past(conv_req) && !$past(ctrl_wr))) else $error("complete without final strobe"); // R5
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_req) |-> !complete) else $error("start left complete set"); // R4
   AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en) else $error("irq while disabled"); // R7
   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |-> (cnt < len_eff)) else $error("count beyond length"); // R2
   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!conv_req && conv_done && !seq_start) |=> !$rose(complete)) else $error("idle strobe counted"); // R6
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_wr   (ctrl_wr),
   .seq_start (seq_start),
   .conv_done (conv_done),
   .conv_req  (conv_req),
   .complete  (complete),
   .irq       (irq),
   .irq_en    (ctrl.irq_en),
   .cnt       (cnt),
   .len_eff   (len_eff)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_addr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       ext_trig = 1'b0;
   logic       conv_done = 1'b0;
   logic       conv_req;
   logic       irq;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   adc_seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
      .conv_done(conv_done), .conv_req(conv_req), .irq(irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic done_pulse();
      @(negedge clk);
      conv_done = 1'b1;
      @(negedge clk);
      conv_done = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic run_len(input string req, input logic [7:0] field, input int exp_len);
      logic [7:0] s;
      wr(1'b0, field);
      wr(1'b1, 8'h01);
      check({req, " started"}, 8'(conv_req), 8'h01);
      for (int i = 0; i < exp_len - 1; i++) done_pulse();
      check({req, " still active before last strobe"}, 8'(conv_req), 8'h01);
      done_pulse();
      check({req, " ended after last strobe"}, 8'(conv_req), 8'h00);
      rd(1'b1, s);
      check({req, " complete set"}, s, 8'h01);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      rd(1'b0, d); check("R1 ctrl reset", d, 8'h04);
      rd(1'b1, d); check("R1 status reset", d, 8'h00);
      check("R1 conv_req reset", 8'(conv_req), 8'h00);
   endtask

   task automatic t_lengths();
      run_len("R1 default length 4", 8'h04, 4);
      run_len("R2 length 1", 8'h01, 1);
      run_len("R2 length 3", 8'h03, 3);
      run_len("R2 length 5", 8'h05, 5);
      run_len("R2 length 8", 8'h08, 8);
      run_len("R3 length 0 -> 8", 8'h00, 8);
      run_len("R3 length 12 -> 8", 8'h0C, 8);
   endtask

   task automatic t_start();
      logic [7:0] d;
      wr(1'b0, 8'h02);
      wr(1'b1, 8'h01);
      rd(1'b1, d); check("R4 start clears complete, active bit", d, 8'h04);
      done_pulse();
      wr(1'b1, 8'h01);
      done_pulse();
      rd(1'b1, d); check("R4 start while active ignored", d, 8'h01);
   endtask

   task automatic t_abort();
      logic [7:0] d;
      wr(1'b0, 8'h03);
      wr(1'b1, 8'h01);
      done_pulse();
      wr(1'b0, 8'h03);
      check("R6 abort drops conv_req", 8'(conv_req), 8'h00);
      repeat (3) done_pulse();
      rd(1'b1, d); check("R6 strobes after abort ignored", d, 8'h00);
   endtask

   task automatic t_irq();
      logic [7:0] d;
      wr(1'b0, 8'h81);
      wr(1'b1, 8'h01);
      done_pulse();
      rd(1'b1, d); check("R7 irq flag with enable", d, 8'h03);
      check("R7 irq output with enable", 8'(irq), 8'h01);
      wr(1'b1, 8'h02);
      rd(1'b1, d); check("R8 write to flag bit no effect", d, 8'h03);
      wr(1'b0, 8'h01);
      rd(1'b1, d); check("R7 flag reads 0 when disabled", d, 8'h01);
      check("R7 irq low when disabled", 8'(irq), 8'h00);
      wr(1'b0, 8'h81);
      check("R7 irq returns on enable", 8'(irq), 8'h01);
      wr(1'b0, 8'h01);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      wr(1'b0, 8'h82);
      wr(1'b1, 8'h01);
      done_pulse();
      @(negedge clk);
      conv_done = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h82;
      @(negedge clk);
      conv_done = 1'b0; bus_wr = 1'b0;
      check("R11 abort wins: conv_req", 8'(conv_req), 8'h00);
      check("R11 abort wins: irq", 8'(irq), 8'h00);
      rd(1'b1, d); check("R11 abort wins: status", d, 8'h00);
   endtask

   task automatic t_trigger();
      ext_trig = 1'b0;
      wr(1'b0, 8'h31);
      idle(4);
      check("R9 rising idle", 8'(conv_req), 8'h00);
      ext_trig = 1'b1; idle(4);
      check("R9 rising starts", 8'(conv_req), 8'h01);
      done_pulse(); idle(4);
      check("R9 rising no retrigger while high", 8'(conv_req), 8'h00);
      wr(1'b0, 8'h11);
      idle(4);
      check("R9 falling ignores high", 8'(conv_req), 8'h00);
      ext_trig = 1'b0; idle(4);
      check("R9 falling starts", 8'(conv_req), 8'h01);
      done_pulse();
      wr(1'b0, 8'h51);
      idle(4);
      check("R9 high mode idle when low", 8'(conv_req), 8'h00);
      ext_trig = 1'b1; idle(4);
      check("R9 high level starts", 8'(conv_req), 8'h01);
      done_pulse();
      check("R10 level run ended", 8'(conv_req), 8'h00);
      idle(2);
      check("R10 level restarts", 8'(conv_req), 8'h01);
      wr(1'b0, 8'h71);
      idle(4);
      check("R9 low mode idle when high", 8'(conv_req), 8'h00);
      ext_trig = 1'b0; idle(4);
      check("R9 low level starts", 8'(conv_req), 8'h01);
      wr(1'b0, 8'h01);
      check("R6 abort with trigger disabled", 8'(conv_req), 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lengths();
      t_start();
      t_abort();
      t_irq();
      t_collide();
      t_trigger();
      idle(2);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule